// File: doc/BRIEF.md
# Triggered Long-Period Timer

This block is a synchronous model of a long-range timer made from an eight-stage binary counter. It has no oscillator of its own. The period source arrives as `tb_tick`, a one-cycle pulse in the system clock domain, and each pulse stands for one falling timebase edge. The trigger and clear requests are asynchronous, active-high inputs. Each passes through a two-flop synchronizer before it is used.

A rising trigger edge sets every counter stage to one. This is the reverse of the all-zero idle state, so both outputs fall together. After that, every tick lowers the count by one. Two inverted outputs come from the counter: one from the least-significant stage (half rate) and one from the most-significant stage (1/256 rate). Both outputs read high while the timer is idle.

The mode input selects free-running or one-shot behaviour. In free-running mode the slow output is a square wave, 128 ticks low and 128 ticks high. In one-shot mode the slow output is fed back into the clear path. The block therefore gives one low pulse of 128 ticks and then returns to idle. A synchronized trigger held high blocks every clear request, including that feedback.

Top module: `lrt_timer`

## Requirements
- R1: After a synchronous active-low reset, `half_n` and `slow_n` are 1 and `running` is 0.
- R2: A rising edge of `trig_in` takes effect on the third clock edge after the input changes. It sets all eight stages to 1, so `half_n` = 0, `slow_n` = 0 and `running` = 1.
- R3: A tick has no effect on the counter while the timer is idle. A tick has no effect in the cycle that loads the counter on a trigger edge.
- R4: While running, each tick lowers the counter by one (modulo 256), takes effect on that clock edge, and toggles `half_n`.
- R5: `slow_n` equals the inverse of stage 7, so it returns high on exactly the 128th tick after the trigger edge. In free-running mode it then stays high for 128 ticks and low for the next 128.
- R6: While the synchronized trigger is low, a synchronized `clr_in` high puts the timer in the idle state (all stages 0) with `running` = 0. This takes effect on the third clock edge after `clr_in` rises.
- R7: While the synchronized trigger is high, clear has no effect: `running` stays 1 and ticks keep counting.
- R8: Once idle, the timer stays idle after clear is released until a new trigger rising edge arrives.
- R9: In one-shot mode (`oneshot_mode` = 1), the cycle after `slow_n` goes high while running (trigger low) enters the idle state.
- R10: A trigger edge while running reloads all stages to 1, so the period restarts.
- R11: `running` rises with a trigger load and falls on entry to the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_tick | input | 1 | One-cycle pulse, one per falling timebase edge |
| trig_in | input | 1 | Asynchronous active-high trigger |
| clr_in | input | 1 | Asynchronous active-high clear |
| oneshot_mode | input | 1 | 1 = one-shot, 0 = free-running |
| half_n | output | 1 | Inverted stage 0 |
| slow_n | output | 1 | Inverted stage 7 |
| running | output | 1 | High while counting |

## Verification
- **Free-running sweep:** 512 consecutive ticks after a trigger, comparing both outputs on every tick against 255 minus the tick count. This separates a correct down-count from an up-count or a wrong stage tap.
- **One-shot sweep:** checks that the low pulse is exactly 128 ticks long and that the feedback returns the timer to idle one cycle later.
- **Timing corners:** a tick aligned with the trigger edge, and ticks sent while idle. These show whether the load and idle states really mask the tick.
- **Clear and trigger overlap:** clear held while the trigger is high, then the trigger dropped, then clear released. This separates the trigger-over-clear priority from the requirement that only a new trigger edge restarts the timer.

// File: rtl/lrt_pkg.sv
// Package: shared constants and the counter command type for the timer.
// Assumes: one command per cycle reaches the counter.
package lrt_pkg;
    localparam int LRT_STAGES = 8;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_LOAD  = 2'd1,
        CNT_CLEAR = 2'd2,
        CNT_DEC   = 2'd3
    } cnt_cmd_t;
endpackage

// File: rtl/lrt_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes: the input is a slow level; only metastability is handled here.
module lrt_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [DEPTH-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            // Purpose: move the level one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else begin
                    if (g == 0) chain[g] <= d_async;
                    else        chain[g] <= chain[(g > 0) ? g-1 : 0];
                end
            end
        end
    endgenerate

    assign q_sync = chain[DEPTH-1];
endmodule

// File: rtl/lrt_ctrl.sv
// Module: control for the timer. Detects the trigger edge, resolves the
// priority between trigger and clear (external and one-shot feedback),
// and issues one counter command per cycle.
// Assumes: trig_s and clr_s are already synchronized to clk.
module lrt_ctrl
    import lrt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     trig_s,
    input  logic     clr_s,
    input  logic     tick,
    input  logic     oneshot,
    input  logic     top_stage,
    output cnt_cmd_t cmd,
    output logic     run_q
);
    logic trig_d;
    logic trig_edge;
    logic fb_clr;
    logic clr_req;

    // Purpose: keep the previous synchronized trigger for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_d <= 1'b0;
        else        trig_d <= trig_s;
    end

    assign trig_edge = trig_s & ~trig_d;
    // One-shot feedback: the slow output is high when the top stage is 0.
    assign fb_clr    = oneshot & run_q & ~top_stage;
    // A high trigger blocks every clear request.
    assign clr_req   = (clr_s | fb_clr) & ~trig_s;

    // Purpose: choose the counter command (load beats clear beats count).
    always_comb begin
        if (trig_edge)          cmd = CNT_LOAD;
        else if (clr_req)       cmd = CNT_CLEAR;
        else if (run_q && tick) cmd = CNT_DEC;
        else                    cmd = CNT_HOLD;
    end

    // Purpose: track whether the timer is counting.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_q <= 1'b0;
        else if (cmd == CNT_LOAD)    run_q <= 1'b1;
        else if (cmd == CNT_CLEAR)   run_q <= 1'b0;
    end

    AST_TRIG_BLOCKS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_s && run_q) |=> run_q) else $error("trigger did not block clear"); // R7
    AST_CLR_ENTERS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && !trig_s) |=> !run_q) else $error("clear did not stop timer"); // R6
    AST_EDGE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_edge |=> run_q) else $error("edge did not start timer"); // R11
endmodule

// File: rtl/lrt_counter.sv
// Module: down-counting chain of stages with load-all-ones and clear.
// Assumes: the command is decoded elsewhere and stays valid for one cycle.
module lrt_counter
    import lrt_pkg::*;
#(
    parameter int WIDTH = LRT_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_cmd_t         cmd,
    output logic [WIDTH-1:0] stages
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    // Purpose: apply the command to the stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else begin
            case (cmd)
                CNT_LOAD:  stages <= ONES;
                CNT_CLEAR: stages <= '0;
                CNT_DEC:   stages <= stages - ONE;
                default:   stages <= stages;
            endcase
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CNT_HOLD) |=> $stable(stages)) else $error("stages moved on hold"); // R3
endmodule

// File: rtl/lrt_timer.sv
// Module: top of the triggered long-period timer. Synchronizes the
// trigger and clear, runs the control and the counter, and drives the
// inverted half-rate and 1/256-rate outputs.
// Assumes: tb_tick is a clean single-cycle pulse in the clk domain.
module lrt_timer
    import lrt_pkg::*;
#(
    parameter int STAGES     = LRT_STAGES,
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_tick,
    input  logic trig_in,
    input  logic clr_in,
    input  logic oneshot_mode,
    output logic half_n,
    output logic slow_n,
    output logic running
);
    localparam int TOP = STAGES - 1;

    logic              trig_s;
    logic              clr_s;
    cnt_cmd_t          cmd;
    logic              run_q;
    logic [STAGES-1:0] stages;

    lrt_sync #(.DEPTH(SYNC_DEPTH)) u_sync_trig (
        .clk(clk), .rst_n(rst_n), .d_async(trig_in), .q_sync(trig_s)
    );
    lrt_sync #(.DEPTH(SYNC_DEPTH)) u_sync_clr (
        .clk(clk), .rst_n(rst_n), .d_async(clr_in), .q_sync(clr_s)
    );

    lrt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_s(trig_s), .clr_s(clr_s),
        .tick(tb_tick), .oneshot(oneshot_mode), .top_stage(stages[TOP]),
        .cmd(cmd), .run_q(run_q)
    );

    lrt_counter #(.WIDTH(STAGES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .stages(stages)
    );

    assign half_n  = ~stages[0];
    assign slow_n  = ~stages[TOP];
    assign running = run_q;

    AST_IDLE_OUTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (half_n && slow_n)) else $error("idle outputs not high"); // R1
    AST_LOAD_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CNT_LOAD) |=> (!half_n && !slow_n && running)) else $error("load bad"); // R2
    AST_TICK_TOGGLES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CNT_DEC) |=> (half_n != $past(half_n))) else $error("half not toggled"); // R4
    AST_ONESHOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_mode && running && slow_n && !trig_s) |=> !running) else $error("one-shot stuck"); // R9
endmodule

// File: tb/lrt_timer_tb.sv
module lrt_timer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_tick = 1'b0;
    logic trig_in = 1'b0;
    logic clr_in = 1'b0;
    logic oneshot_mode = 1'b0;
    logic half_n, slow_n, running;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    lrt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .trig_in(trig_in),
        .clr_in(clr_in), .oneshot_mode(oneshot_mode),
        .half_n(half_n), .slow_n(slow_n), .running(running)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {half_n,slow_n,running} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick_once();
        tb_tick = 1'b1;
        step(1);
        tb_tick = 1'b0;
    endtask

    // Raise trigger and wait for the load (third edge), then drop it.
    task automatic fire();
        trig_in = 1'b1;
        step(3);
        trig_in = 1'b0;
        step(2);
    endtask

    // Expected output word for count value c while running.
    function automatic logic [2:0] exp_run(input int c);
        logic [7:0] v;
        v = 8'(c);
        return {~v[0], ~v[7], 1'b1};
    endfunction

    initial begin
        @(negedge clk);
        step(2);
        rst_n = 1'b1;
        step(1);
        check("R1 reset state", {half_n, slow_n, running}, 3'b110);

        // R3: ticks while idle change nothing
        for (int i = 0; i < 5; i++) tick_once();
        check("R3 idle ticks ignored", {half_n, slow_n, running}, 3'b110);

        // R2 + R3: tick in the load cycle is ignored
        trig_in = 1'b1;
        step(2);
        check("R2 not yet loaded after two edges", {half_n, slow_n, running}, 3'b110);
        tick_once();
        check("R2 load, R3 aligned tick ignored", {half_n, slow_n, running}, exp_run(255));
        trig_in = 1'b0;
        step(2);

        // R4/R5: free-running sweep over two full periods
        for (int k = 1; k <= 512; k++) begin
            tick_once();
            check((k == 128) ? "R5 slow returns high at 128" : "R4 free-run count",
                  {half_n, slow_n, running}, exp_run(255 - k));
        end

        // R10: retrigger mid-count reloads
        for (int i = 0; i < 40; i++) tick_once();
        fire();
        check("R10 retrigger reload", {half_n, slow_n, running}, exp_run(255));

        // R6: clear with trigger low
        clr_in = 1'b1;
        step(2);
        check("R6 clear not yet seen", {half_n, slow_n, running}, exp_run(255));
        step(1);
        check("R6 clear enters idle", {half_n, slow_n, running}, 3'b110);
        clr_in = 1'b0;
        step(3);

        // R7: trigger held high overrides clear
        trig_in = 1'b1;
        step(3);
        clr_in = 1'b1;
        step(4);
        check("R7 clear blocked by trigger", {half_n, slow_n, running}, exp_run(255));
        tick_once();
        check("R7 ticks count under clear", {half_n, slow_n, running}, exp_run(254));
        trig_in = 1'b0;
        step(3);
        check("R6 clear acts after trigger falls", {half_n, slow_n, running}, 3'b110);

        // R8: release clear, stay idle
        clr_in = 1'b0;
        step(3);
        for (int i = 0; i < 3; i++) tick_once();
        check("R8 idle after clear release", {half_n, slow_n, running}, 3'b110);

        // R9: one-shot pulse of exactly 128 ticks
        oneshot_mode = 1'b1;
        fire();
        check("R11 running after trigger", {half_n, slow_n, running}, exp_run(255));
        for (int k = 1; k <= 127; k++) begin
            tick_once();
            check("R9 one-shot low phase", {half_n, slow_n, running}, exp_run(255 - k));
        end
        tick_once();
        check("R9 slow high at 128th tick", {half_n, slow_n, running}, exp_run(127));
        step(1);
        check("R9 feedback returns idle", {half_n, slow_n, running}, 3'b110);
        for (int i = 0; i < 4; i++) tick_once();
        check("R8 one-shot stays idle", {half_n, slow_n, running}, 3'b110);

        // R1: reset mid-run
        oneshot_mode = 1'b0;
        fire();
        tick_once();
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        check("R1 reset mid-run", {half_n, slow_n, running}, 3'b110);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule